// File: doc/BRIEF.md
# Event Counter Bank for Interconnect Performance Monitoring

This block holds eight event counters that software reaches through a small memory-mapped register bus. Each counter picks one event line out of a strobe vector. The vector is laid out by upstream interface index and event number. While enabled, the counter adds one on every cycle in which its chosen line is high. A counter that rolls past its top value latches an overflow flag, and that flag drives an interrupt line belonging to that counter alone. Software clears the flag by writing a one to it.

Two debug-enable inputs gate counting. The invasive enable must be high for any counter to move. An interface whose events are marked secure is counted only when the secure invasive enable is high as well. Register reads are combinational on the address, so they answer in the same cycle. Writes take effect at the next clock edge.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset, every register of every counter reads zero and every interrupt output is low.
- R2: Counter n (0 to 7) answers where address bits [19:16] equal n+1, bits [15:4] are zero and bits [1:0] are zero. The low nibble 0x0 is the event selector, 0x4 the count, 0x8 the control and 0xC the overflow flag. Any other address reads zero.
- R3: The selector keeps write-data bits [8:0]: bits [8:5] name the interface and bits [4:0] name the event. It reads back these nine bits with all upper bits zero.
- R4: Control bit 0 enables the counter. While it is zero, the count holds its value.
- R5: Strobe bit i*32+e carries event e of interface i, for interfaces 0 to 6. An enabled counter adds one per cycle only when its selected strobe is high and e is one of 3, 4, 5, 6, 7 or 9. A different strobe, an unrecognised event number or an interface above 6 never adds.
- R6: The count is 32 bits and wraps from 0xFFFFFFFF to 0. On that wrap, overflow flag bit 0 sets and the counter's interrupt output goes high in the following cycle.
- R7: Writing the overflow register with bit 0 set clears the flag and drops the interrupt. Writing it with bit 0 clear changes nothing. A wrap in the same cycle as a clear leaves the flag set.
- R8: While the invasive debug enable is low, no counter advances.
- R9: When ev_secure[i] is high, events of interface i advance a counter only while both the invasive and the secure invasive enables are high.
- R10: A write to the count register loads the write data. In a cycle where the selected event also fires, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_inv_en | input | 1 | Invasive debug enable; gates all counting |
| sec_inv_en | input | 1 | Secure invasive debug enable; also gates secure interfaces |
| ev_strobe | input | NUM_IF*32 | Event strobes, bit i*32+e for interface i, event e |
| ev_secure | input | NUM_IF | Per-interface flag marking its events as secure |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as a read; zero otherwise |
| ctr_irq | output | NUM_CTR | Per-counter overflow interrupt |

## Verification
The bench builds the block with its defaults: eight counters, seven interfaces, 32-bit counts and a 20-bit address. With these values the lowest group (0x10000) and the highest group (0x80000) are both reachable, and so are the unmapped group just above them and the offsets inside a group. Preloading a count of 0xFFFFFFFE brings the 32-bit wrap within a few cycles. Interface 2 is marked secure so that both debug gates are exercised, and interface 6 with event 9 covers the top of the strobe vector.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int EVT_W = 5;
  localparam int IF_W  = 4;
  localparam int SEL_W = IF_W + EVT_W;
  localparam int GRP_W = 4;

  typedef enum logic [1:0] {
    OFS_SEL = 2'd0,
    OFS_CNT = 2'd1,
    OFS_CTL = 2'd2,
    OFS_OVF = 2'd3
  } reg_ofs_e;

  // event numbers that the bank knows how to count
  function automatic logic evt_known(input logic [EVT_W-1:0] ev);
    case (ev)
      5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd9: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pmu_addr_dec.sv
module pmu_addr_dec
  import pmu_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int NUM_CTR = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CTR-1:0] grp_oh,
  output reg_ofs_e          ofs,
  output logic              rd_hit,
  output logic [NUM_CTR-1:0] wr_sel,
  output logic [NUM_CTR-1:0] wr_cnt,
  output logic [NUM_CTR-1:0] wr_ctl,
  output logic [NUM_CTR-1:0] wr_ovf
);
  localparam int MID_W = ADDR_W - GRP_W - 4;

  logic [GRP_W-1:0] grp_f;
  logic             mapped;

  assign grp_f  = bus_addr[ADDR_W-1 -: GRP_W];
  assign ofs    = reg_ofs_e'(bus_addr[3:2]);
  assign mapped = bus_sel && (bus_addr[ADDR_W-GRP_W-1 -: MID_W] == '0)
               && (bus_addr[1:0] == 2'b00);
  assign rd_hit = mapped && !bus_wr;

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_dec
    logic hit_n;
    assign hit_n     = mapped && (grp_f == GRP_W'(n + 1));
    assign grp_oh[n] = hit_n;
    assign wr_sel[n] = hit_n && bus_wr && (ofs == OFS_SEL);
    assign wr_cnt[n] = hit_n && bus_wr && (ofs == OFS_CNT);
    assign wr_ctl[n] = hit_n && bus_wr && (ofs == OFS_CTL);
    assign wr_ovf[n] = hit_n && bus_wr && (ofs == OFS_OVF);
  end
endmodule

// File: rtl/pmu_evt_pick.sv
module pmu_evt_pick
  import pmu_pkg::*;
#(
  parameter int NUM_IF = 7
) (
  input  logic [SEL_W-1:0]             evsel,
  input  logic [NUM_IF*(1<<EVT_W)-1:0] ev_strobe,
  input  logic [NUM_IF-1:0]            ev_secure,
  input  logic                         dbg_inv_en,
  input  logic                         sec_inv_en,
  output logic                         ev_hit
);
  localparam int NUM_EVT = 1 << EVT_W;
  localparam int TOT     = NUM_IF * NUM_EVT;

  logic [IF_W-1:0]  ifx;
  logic [EVT_W-1:0] evn;
  logic             in_range;
  logic [15:0]      idx;
  logic [TOT-1:0]   str_sh;
  logic [NUM_IF-1:0] sec_sh;
  logic             gate_ok;

  assign ifx      = evsel[SEL_W-1 -: IF_W];
  assign evn      = evsel[EVT_W-1:0];
  assign in_range = 32'(ifx) < NUM_IF;
  assign idx      = 16'(ifx) * 16'(NUM_EVT) + 16'(evn);
  assign str_sh   = ev_strobe >> idx;
  assign sec_sh   = ev_secure >> ifx;
  assign gate_ok  = dbg_inv_en && (!sec_sh[0] || sec_inv_en);
  assign ev_hit   = in_range && str_sh[0] && evt_known(evn) && gate_ok;
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic              wr_cnt,
  input  logic              wr_ctl,
  input  logic              wr_ovf,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_hit,
  output logic [SEL_W-1:0]  evsel,
  output logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              ovf,
  output logic              inc,
  output logic              wrap
);
  logic [CNT_W:0] sum;

  assign inc  = en && ev_hit;
  assign sum  = {1'b0, cnt} + 1'b1;
  assign wrap = inc && !wr_cnt && sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evsel <= '0;
      cnt   <= '0;
      en    <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (wr_sel) evsel <= wdata[SEL_W-1:0];
      if (wr_ctl) en    <= wdata[0];
      if (wr_cnt)   cnt <= wdata[CNT_W-1:0];
      else if (inc) cnt <= sum[CNT_W-1:0];
      if (wrap)                     ovf <= 1'b1;
      else if (wr_ovf && wdata[0])  ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int NUM_IF  = 7,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         dbg_inv_en,
  input  logic                         sec_inv_en,
  input  logic [NUM_IF*(1<<EVT_W)-1:0] ev_strobe,
  input  logic [NUM_IF-1:0]            ev_secure,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [NUM_CTR-1:0]           ctr_irq
);
  logic [NUM_CTR-1:0]            grp_oh;
  reg_ofs_e                      ofs;
  logic                          rd_hit;
  logic [NUM_CTR-1:0]            wr_sel, wr_cnt, wr_ctl, wr_ovf;
  logic [NUM_CTR-1:0][SEL_W-1:0] evsel_q;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_CTR-1:0]            en_q, ovf_q, ev_hit, inc_q, wrap_q;

  pmu_addr_dec #(.ADDR_W(ADDR_W), .NUM_CTR(NUM_CTR)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .grp_oh(grp_oh), .ofs(ofs), .rd_hit(rd_hit),
    .wr_sel(wr_sel), .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .wr_ovf(wr_ovf)
  );

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    pmu_evt_pick #(.NUM_IF(NUM_IF)) u_pick (
      .evsel(evsel_q[n]), .ev_strobe(ev_strobe), .ev_secure(ev_secure),
      .dbg_inv_en(dbg_inv_en), .sec_inv_en(sec_inv_en), .ev_hit(ev_hit[n])
    );
    pmu_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(wr_sel[n]), .wr_cnt(wr_cnt[n]), .wr_ctl(wr_ctl[n]), .wr_ovf(wr_ovf[n]),
      .wdata(bus_wdata), .ev_hit(ev_hit[n]),
      .evsel(evsel_q[n]), .cnt(cnt_q[n]), .en(en_q[n]), .ovf(ovf_q[n]),
      .inc(inc_q[n]), .wrap(wrap_q[n])
    );
  end

  assign ctr_irq = ovf_q;

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (rd_hit && grp_oh[n]) begin
        case (ofs)
          OFS_SEL: bus_rdata = DATA_W'(evsel_q[n]);
          OFS_CNT: bus_rdata = DATA_W'(cnt_q[n]);
          OFS_CTL: bus_rdata = DATA_W'(en_q[n]);
          OFS_OVF: bus_rdata = DATA_W'(ovf_q[n]);
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pmu_counter_bank_chk.sv
module pmu_counter_bank_chk #(
  parameter int NUM_CTR = 8,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          dbg_inv_en,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [NUM_CTR-1:0]            ctr_irq,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt_q,
  input logic [NUM_CTR-1:0]            wr_cnt,
  input logic [NUM_CTR-1:0]            wr_ovf,
  input logic [NUM_CTR-1:0]            en_q,
  input logic [NUM_CTR-1:0]            inc_q,
  input logic [NUM_CTR-1:0]            wrap_q
);
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    a_r6_irq_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_q[k] |=> ctr_irq[k]);
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      inc_q[k] && !wr_cnt[k] |=> cnt_q[k] == $past(cnt_q[k]) + 1'b1);
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_irq[k] && !(wr_ovf[k] && bus_wdata[0]) |=> ctr_irq[k]);
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ovf[k] && bus_wdata[0] && !wrap_q[k] |=> !ctr_irq[k]);
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt[k] |=> cnt_q[k] == $past(bus_wdata[CNT_W-1:0]));
    a_r4_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[k] && !wr_cnt[k] |=> $stable(cnt_q[k]));
    a_r8_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_inv_en && !wr_cnt[k] |=> $stable(cnt_q[k]));
  end
endmodule

bind pmu_counter_bank pmu_counter_bank_chk #(
  .NUM_CTR(NUM_CTR), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_inv_en(dbg_inv_en), .bus_wdata(bus_wdata),
  .ctr_irq(ctr_irq), .cnt_q(cnt_q), .wr_cnt(wr_cnt), .wr_ovf(wr_ovf),
  .en_q(en_q), .inc_q(inc_q), .wrap_q(wrap_q)
);

// File: tb/pmu_counter_bank_tb.sv
module pmu_counter_bank_tb;
  localparam int NUM_CTR = 8;
  localparam int NUM_IF  = 7;
  localparam int ADDR_W  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_inv_en = 1'b1, sec_inv_en = 1'b1;
  logic [NUM_IF*32-1:0] ev_strobe = '0;
  logic [NUM_IF-1:0]    ev_secure = '0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_CTR-1:0] ctr_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string req; logic [ADDR_W-1:0] addr; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  pmu_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_inv_en(dbg_inv_en), .sec_inv_en(sec_inv_en),
    .ev_strobe(ev_strobe), .ev_secure(ev_secure), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctr_irq(ctr_irq)
  );

  function automatic logic [ADDR_W-1:0] ra(int ctr, int ofs);
    return ADDR_W'((ctr + 1) << 16) | ADDR_W'(ofs);
  endfunction

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  // driver: pushes the expected item, monitor compares it
  task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] e, string req);
    item_t it;
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.exp = e; it.req = req; it.addr = a;
    sb_q.push_back(it);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic pulse(int idx, int cyc);
    @(negedge clk); ev_strobe[idx] = 1'b1;
    repeat (cyc) @(negedge clk);
    ev_strobe[idx] = 1'b0;
  endtask

  task automatic chk_irq(logic [NUM_CTR-1:0] e, string req);
    @(negedge clk); #5;
    n_chk++;
    if (ctr_irq !== e) begin
      n_err++;
      $display("FAIL %s irq actual=%b expected=%b", req, ctr_irq, e);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk); #5;
      if (bus_sel && !bus_wr) begin
        item_t it;
        if (sb_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
        end else begin
          it = sb_q.pop_front();
          n_chk++;
          if (bus_rdata !== it.exp) begin
            n_err++;
            $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int r = 0; r < 16; r += 4) rd(ra(0, r), 0, "R1");
    for (int r = 0; r < 16; r += 4) rd(ra(7, r), 0, "R1");
    chk_irq('0, "R1");

    // R3 selector fields and masking
    wr(ra(0, 0), 32'h0000_0043);
    rd(ra(0, 0), 32'h43, "R3");
    wr(ra(0, 0), 32'hFFFF_FE43);
    rd(ra(0, 0), 32'h43, "R3");

    // R4/R5 enable and counting on interface 2 event 3
    wr(ra(0, 8), 1);
    rd(ra(0, 8), 1, "R4");
    wr(ra(1, 0), 32'h43);            // counter 1 same event, left disabled
    pulse(2*32+3, 5); c0 = 5;
    rd(ra(0, 4), c0, "R5");
    rd(ra(1, 4), 0, "R4");
    pulse(2*32+4, 3);                // other strobe
    rd(ra(0, 4), c0, "R5");

    // R5 unrecognised event 8 on interface 0
    wr(ra(2, 0), 32'h8); wr(ra(2, 8), 1);
    pulse(8, 3);
    rd(ra(2, 4), 0, "R5");

    // R8 invasive enable off
    dbg_inv_en = 0;
    pulse(2*32+3, 4);
    rd(ra(0, 4), c0, "R8");
    dbg_inv_en = 1;

    // R9 secure interface 2
    ev_secure[2] = 1; sec_inv_en = 0;
    pulse(2*32+3, 3);
    rd(ra(0, 4), c0, "R9");
    sec_inv_en = 1;
    pulse(2*32+3, 2); c0 += 2;
    rd(ra(0, 4), c0, "R9");
    ev_secure[2] = 0;

    // R6 wrap after preload
    wr(ra(0, 4), 32'hFFFF_FFFE);
    rd(ra(0, 4), 32'hFFFF_FFFE, "R10");
    pulse(2*32+3, 2);
    rd(ra(0, 4), 0, "R6");
    rd(ra(0, 12), 1, "R6");
    chk_irq(8'h01, "R6");

    // R7 write-1-to-clear
    wr(ra(0, 12), 0);
    chk_irq(8'h01, "R7");
    wr(ra(0, 12), 1);
    rd(ra(0, 12), 0, "R7");
    chk_irq(8'h00, "R7");

    // R10 write wins over same-cycle event
    @(negedge clk);
    ev_strobe[2*32+3] = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = ra(0, 4); bus_wdata = 100;
    @(negedge clk);
    ev_strobe[2*32+3] = 0; bus_sel = 0; bus_wr = 0;
    rd(ra(0, 4), 100, "R10");

    // R2 top group, interface 6 event 9, unmapped addresses
    wr(ra(7, 0), (6 << 5) | 9); wr(ra(7, 8), 1);
    pulse(6*32+9, 4);
    rd(ra(7, 4), 4, "R2");
    rd(ADDR_W'(20'h9_0000), 0, "R2");
    rd(ADDR_W'(20'h1_0010), 0, "R2");
    rd(ADDR_W'(20'h0_0004), 0, "R2");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule